// File: doc/BRIEF.md
# Serial Receive Bit-Sampling Timer

This block paces the capture of one asynchronous serial frame carrying eight data bits and one stop bit. The system clock runs at a fixed multiple of the bit rate, ten by default. Once the receive controller enables it after a falling start edge, the timer counts clock cycles and captured bits. It emits a single-cycle shift strobe near the middle of each bit that must be stored. The start bit is passed over without a strobe. After the last strobe, a one-cycle completion pulse tells the controller that the frame is in the shift register.

The distance from enable to the first strobe is one and a half bit periods, less a fixed number of cycles already spent detecting the start edge. After that, strobes are spaced by exactly one bit period. A parameter selects how the enable is interpreted. In level mode, the enable must stay high for the whole frame, and dropping it aborts the frame. In trigger mode, a single enabled cycle starts a frame that runs to completion. In both modes, a finished frame stays quiet until the enable has been low and rises again.

Top module: `uart_rx_bit_timer`

## Requirements
- R1: While `rst` is high at a rising edge, both outputs are 0 after that edge and all counting restarts from zero. An idle timer (enable low, no frame running) drives both outputs at 0.
- R2: `shift_strobe` is high for exactly one clock cycle at a time.
- R3: Number the rising edges at which a new frame's enable is sampled high, starting from 1. The first strobe is high in the cycle that follows edge G, where G = CLKS_PER_BIT + CLKS_PER_BIT/2 - DETECT_LAG (13 by default).
- R4: Each later strobe follows the previous one by exactly CLKS_PER_BIT cycles, and exactly FRAME_BITS strobes (9 by default) occur per frame.
- R5: `frame_done` is high for exactly one cycle, the cycle right after the last strobe of a frame. It is never high together with `shift_strobe`.
- R6: After `frame_done`, no further strobe or done occurs while the enable stays high. Lowering the enable and raising it again starts a fresh frame with the R3 timing.
- R7: In level mode, a low enable sampled at an edge stops the frame. No strobe follows that edge, no done is issued for the frame, and the next frame starts from zero.
- R8: In trigger mode, an enable high for a single edge while idle produces the full frame of R3 to R5.
- R9: In trigger mode, enable activity while a frame runs does not change its strobe or done timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, a fixed multiple of the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| timer_en | input | 1 | Timer enable from the receive controller |
| shift_strobe | output | 1 | One-cycle pulse: shift the serial line in now |
| frame_done | output | 1 | One-cycle pulse: all frame bits captured |

## Verification
The bench builds two instances. The first uses the default level-mode configuration (10 clocks per bit, 9 strobes, lag 2), so every strobe position can be checked. It also sweeps the abort edge over every cycle of the frame and a few cycles past it. The second uses a small trigger-mode configuration (6 clocks per bit, 4 strobes, lag 1), which is small enough to try every pulse width up to the last strobe and several enable-toggling patterns during a frame. In every run, each cycle's outputs are compared with the positions computed arithmetically from G, the bit period and the frame length.

// File: rtl/rxt_pkg.sv
package rxt_pkg;
  typedef enum logic {
    EN_LEVEL   = 1'b0,
    EN_TRIGGER = 1'b1
  } en_mode_e;

  function automatic int first_gap(input int clks_per_bit, input int detect_lag);
    return clks_per_bit + clks_per_bit / 2 - detect_lag;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rxt_cycle_counter.sv
module rxt_cycle_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  output logic [WIDTH-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else              count <= count + WIDTH'(1);
  end
endmodule

// File: rtl/rxt_bit_counter.sv
module rxt_bit_counter #(
  parameter int FRAME_BITS = 9,
  localparam int BIT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic none_yet,
  output logic on_last
);
  logic [BIT_W-1:0] taken;

  always_ff @(posedge clk) begin
    if (rst || clear) taken <= '0;
    else if (step)    taken <= taken + BIT_W'(1);
  end

  assign none_yet = (taken == '0);
  assign on_last  = (taken == BIT_W'(FRAME_BITS - 1));
endmodule

// File: rtl/rxt_run_ctrl.sv
module rxt_run_ctrl
  import rxt_pkg::*;
#(
  parameter en_mode_e EN_MODE = EN_LEVEL
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic final_hit,
  output logic active
);
  logic finished;

  // A completed frame stays closed until the enable is seen low.
  always_ff @(posedge clk) begin
    if (rst)            finished <= 1'b0;
    else if (final_hit) finished <= 1'b1;
    else if (!enable)   finished <= 1'b0;
  end

  if (EN_MODE == EN_TRIGGER) begin : g_trigger
    logic busy;
    always_ff @(posedge clk) begin
      if (rst) busy <= 1'b0;
      else     busy <= active && !final_hit;
    end
    assign active = (enable || busy) && !finished;
  end else begin : g_level
    assign active = enable && !finished;
  end
endmodule

// File: rtl/uart_rx_bit_timer.sv
module uart_rx_bit_timer
  import rxt_pkg::*;
#(
  parameter int       CLKS_PER_BIT = 10,
  parameter int       FRAME_BITS   = 9,
  parameter int       DETECT_LAG   = 2,
  parameter en_mode_e EN_MODE      = EN_LEVEL
) (
  input  logic clk,
  input  logic rst,
  input  logic timer_en,
  output logic shift_strobe,
  output logic frame_done
);
  localparam int FIRST_GAP = first_gap(CLKS_PER_BIT, DETECT_LAG);
  localparam int GAP_MAX   = max2(FIRST_GAP, CLKS_PER_BIT);
  localparam int CNT_W     = $clog2(GAP_MAX + 1);

  logic             active;
  logic             first_pending;
  logic             last_bit;
  logic             hit;
  logic             final_hit;
  logic [CNT_W-1:0] cyc;
  logic             final_q;

  assign hit = active &&
               (cyc == (first_pending ? CNT_W'(FIRST_GAP - 1) : CNT_W'(CLKS_PER_BIT - 1)));
  assign final_hit = hit && last_bit;

  rxt_run_ctrl #(.EN_MODE(EN_MODE)) i_run (
    .clk       (clk),
    .rst       (rst),
    .enable    (timer_en),
    .final_hit (final_hit),
    .active    (active)
  );

  rxt_cycle_counter #(.WIDTH(CNT_W)) i_cyc (
    .clk   (clk),
    .rst   (rst),
    .clear (!active || hit),
    .count (cyc)
  );

  rxt_bit_counter #(.FRAME_BITS(FRAME_BITS)) i_bits (
    .clk      (clk),
    .rst      (rst),
    .clear    (!active),
    .step     (hit),
    .none_yet (first_pending),
    .on_last  (last_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_strobe <= 1'b0;
      final_q      <= 1'b0;
      frame_done   <= 1'b0;
    end else begin
      shift_strobe <= hit;
      final_q      <= final_hit;
      frame_done   <= final_q;
    end
  end
endmodule

// File: rtl/rxt_checker.sv
module rxt_checker
  import rxt_pkg::*;
#(
  parameter en_mode_e EN_MODE = EN_LEVEL
) (
  input logic clk,
  input logic rst,
  input logic timer_en,
  input logic shift_strobe,
  input logic frame_done
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!shift_strobe && !frame_done));

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
    shift_strobe |=> !shift_strobe);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  assert_done_after_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(shift_strobe));

  assert_done_apart_R5: assert property (@(posedge clk) disable iff (rst)
    !(frame_done && shift_strobe));

  if (EN_MODE == EN_LEVEL) begin : g_level_chk
    assert_abort_quiet_R7: assert property (@(posedge clk) disable iff (rst)
      !timer_en |=> !shift_strobe);
  end
endmodule

bind uart_rx_bit_timer rxt_checker #(.EN_MODE(EN_MODE)) i_rxt_checker (
  .clk          (clk),
  .rst          (rst),
  .timer_en     (timer_en),
  .shift_strobe (shift_strobe),
  .frame_done   (frame_done)
);

// File: tb/test_uart_rx_bit_timer.sv
module test_uart_rx_bit_timer;
  import rxt_pkg::*;

  localparam int LC = 10, LF = 9, LD = 2;
  localparam int LG = LC + LC / 2 - LD;
  localparam int LL = LG + (LF - 1) * LC;
  localparam int TC = 6, TF = 4, TD = 1;
  localparam int TG = TC + TC / 2 - TD;
  localparam int TL = TG + (TF - 1) * TC;
  localparam int NEVER = 1 << 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_l = 1'b0, en_t = 1'b0;
  logic stb_l, done_l, stb_t, done_t;
  int   tests = 0, fails = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  uart_rx_bit_timer #(.CLKS_PER_BIT(LC), .FRAME_BITS(LF), .DETECT_LAG(LD),
                      .EN_MODE(EN_LEVEL)) i_uart_rx_bit_timer (
    .clk(clk), .rst(rst), .timer_en(en_l), .shift_strobe(stb_l), .frame_done(done_l));

  uart_rx_bit_timer #(.CLKS_PER_BIT(TC), .FRAME_BITS(TF), .DETECT_LAG(TD),
                      .EN_MODE(EN_TRIGGER)) i_uart_rx_bit_timer_trig (
    .clk(clk), .rst(rst), .timer_en(en_t), .shift_strobe(stb_t), .frame_done(done_t));

  function automatic bit exp_stb(int e, int a, int g, int c, int f);
    return (e <= a) && (e >= g) && ((e - g) % c == 0) && ((e - g) / c < f);
  endfunction

  function automatic bit exp_done(int e, int a, int l);
    return (e == l + 1) && (l <= a);
  endfunction

  task automatic chk(input bit act, input bit exp, input string req, input string what, input int e);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at edge %0d: actual %0b expected %0b", req, what, e, act, exp);
    end
  endtask

  // Level instance: enable high for edges 1..a, low afterwards.
  task automatic run_level(input int a, input int n, input string req);
    for (int e = 1; e <= n; e++) begin
      en_l = (e <= a);
      @(posedge clk); @(negedge clk);
      chk(stb_l,  exp_stb(e, a, LG, LC, LF), req, "level strobe", e);
      chk(done_l, exp_done(e, a, LL),        req, "level done", e);
    end
    en_l = 1'b0;
    for (int e = 1; e <= 3; e++) begin
      @(posedge clk); @(negedge clk);
      chk(stb_l | done_l, 1'b0, "R1", "level idle", e);
    end
  endtask

  // Trigger instance: enable high for edges 1..w, plus a toggle every gp edges up to the last strobe.
  task automatic run_trig(input int w, input int gp, input string req);
    for (int e = 1; e <= TL + 6; e++) begin
      en_t = (e <= w) || (gp > 0 && e <= TL && e % gp == 0);
      @(posedge clk); @(negedge clk);
      chk(stb_t,  exp_stb(e, NEVER, TG, TC, TF), req, "trigger strobe", e);
      chk(done_t, exp_done(e, NEVER, TL),        req, "trigger done", e);
    end
    en_t = 1'b0;
    for (int e = 1; e <= 3; e++) begin
      @(posedge clk); @(negedge clk);
      chk(stb_t | done_t, 1'b0, "R1", "trigger idle", e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset with enables held high
    en_l = 1'b1; en_t = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(stb_l | done_l | stb_t | done_t, 1'b0, "R1", "outputs in reset", 0);
    en_l = 1'b0; en_t = 1'b0; rst = 1'b0;
    for (int e = 1; e <= 20; e++) begin
      @(posedge clk); @(negedge clk);
      chk(stb_l | done_l | stb_t | done_t, 1'b0, "R1", "idle after reset", e);
    end

    // R3 R4 R5 R6: full held frames with a long tail
    run_level(NEVER, LL + 25, "R3");
    run_level(NEVER, LL + 25, "R6");

    // R1: reset mid-frame then a fresh frame
    for (int e = 1; e <= LG + 12; e++) begin
      en_l = 1'b1; @(posedge clk); @(negedge clk);
    end
    rst = 1'b1; @(posedge clk); @(negedge clk);
    chk(stb_l | done_l, 1'b0, "R1", "mid-frame reset", 0);
    rst = 1'b0; en_l = 1'b0;
    @(posedge clk); @(negedge clk);
    run_level(NEVER, LL + 5, "R1");

    // R7: abort at every edge through the frame
    for (int a = 0; a <= LL + 2; a++) run_level(a, LL + 8, "R7");

    // R8: trigger pulses of every width up to the last strobe
    for (int w = 1; w <= TL; w++) run_trig(w, 0, "R8");
    // R9: enable toggling during the frame
    for (int gp = 2; gp <= 7; gp++) run_trig(1, gp, "R9");
    run_trig(TL, 0, "R4");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule